// File: doc/BRIEF.md
# Laser Power Calibration Sequencer

This block searches for the laser drive setting that gives the cleanest readback on a reserved test zone. It runs a calibration pass in three phases, always in the same order. In the write phase it holds write-enable high and raises the power code one step at a time. In the readback phase it walks through the same codes again with read-enable high. For each step it gathers the peak, trough and mean of three sampled readback channels over a dwell window. In the evaluate phase it scans the reduced per-step results and keeps the code whose peak-to-trough spread lies closest to a programmed target. The spread stands in for jitter here.

The first pass is coarse: 16 codes spaced evenly across the whole 8-bit range. The second pass is fine: 16 adjacent codes centred on the coarse winner and clamped so that they stay within the code range. After the fine pass the winning code appears on `final_code` with a one-cycle `done` pulse. A sample strobe comes from the system clock through a programmable divider, and each step lasts a programmable power-of-two number of strobes. The per-step metric and mean from the latest readback phase stay available through a small indexed read port, so a controller only reads reduced values. A pulse on `start` launches the search. A pulse on `abort` halts it at any point.

Top module: `laser_cal_seq`

## Requirements
- R1: After a `start` pulse in idle, `busy` is high from the next cycle until the search completes. Completion is one cycle with `done` high, `busy` low and `final_code` valid. `done` never stays high for two cycles.
- R2: Each pass runs write (`write_en`=1), then readback (`read_en`=1), then evaluate (both low). `write_en` and `read_en` are never high together, and neither is high outside `busy`. The first busy cycle is a write cycle.
- R3: While `write_en` stays high, `power_code` never decreases. In the coarse pass, step k (k = 0..15) uses code 17*k, so the codes run from 0 to 255.
- R4: The strobe fires once every `div_limit`+1 clock cycles. Each step lasts 2^`dwell_log2` strobes. For `div_limit`=1 and `dwell_log2`=1, code 0 lasts four cycles after start, and code 17 appears on the fifth.
- R5: Per readback step, spread = max(0, largest `smp_max` − smallest `smp_min`). The metric is |spread − `target_spread`|. The mean is the sum of the `smp_avg` samples shifted right by `dwell_log2`.
- R6: The selected code is the evaluated code with the smallest metric. When metrics are equal, the lower code wins.
- R7: The fine pass uses codes lo..lo+15, where lo = clamp(best_coarse − 8, 0, 240).
- R8: `rd_idx` = i returns the metric (`rd_metric`) and mean (`rd_avg`) that were stored for step i of the most recent readback phase.
- R9: On the cycle after `abort` is high, `power_code` is 0 and both `write_en` and `busy` are low, and no `done` follows.
- R10: Out of reset, `busy`, `done`, `write_en`, `read_en` and `power_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted in idle |
| abort | input | 1 | Stop and return to idle |
| div_limit | input | 16 | Strobe divider: period is value+1 cycles |
| dwell_log2 | input | 3 | log2 of strobes per step |
| target_spread | input | 8 | Desired peak-to-trough spread |
| smp_max | input | 8 | Sampled readback peak channel |
| smp_min | input | 8 | Sampled readback trough channel |
| smp_avg | input | 8 | Sampled readback mean channel |
| rd_idx | input | 4 | Step index for the result port |
| power_code | output | 8 | Laser power control code |
| write_en | output | 1 | Test-write enable |
| read_en | output | 1 | Readback capture window |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| final_code | output | 8 | Selected power code |
| rd_metric | output | 8 | Stored metric of step `rd_idx` |
| rd_avg | output | 8 | Stored mean of step `rd_idx` |

## Verification
The properties assume that `start` and `abort` are synchronous pulses and that `div_limit` and `dwell_log2` stay constant while `busy` is high. The bench changes them only in idle. The properties also assume that the sample channels follow the present `power_code` within one cycle, and the bench's readback model is a combinational function of that port. The model's spread never exceeds the 8-bit range, so the metric it expects needs no saturation. It also makes ties occur on purpose, so the lower-code rule is exercised.

// File: rtl/lcal_pkg.sv
package lcal_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WRITE = 2'd1,
      PH_READ  = 2'd2,
      PH_EVAL  = 2'd3
   } lcal_phase_e;
endpackage

// File: rtl/lcal_strobe_div.sv
module lcal_strobe_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [DIV_W-1:0] limit,
   output logic             strobe
);
   logic [DIV_W-1:0] cnt_q;

   assign strobe = (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (strobe) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lcal_step_acc.sv
module lcal_step_acc #(
   parameter int SMP_W = 8,
   parameter int CNT_W = 7,
   parameter int LOG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             smp_en,
   input  logic [LOG_W-1:0] dwell_log2,
   input  logic [SMP_W-1:0] target,
   input  logic [SMP_W-1:0] s_max,
   input  logic [SMP_W-1:0] s_min,
   input  logic [SMP_W-1:0] s_avg,
   output logic [SMP_W-1:0] res_metric,
   output logic [SMP_W-1:0] res_avg
);
   localparam int SUM_W = SMP_W + CNT_W + 1;

   logic [SMP_W-1:0] hi_q, lo_q, hi_n, lo_n, spread;
   logic [SUM_W-1:0] sum_q, sum_n;

   always_comb begin
      hi_n   = (smp_en && (s_max > hi_q)) ? s_max : hi_q;
      lo_n   = (smp_en && (s_min < lo_q)) ? s_min : lo_q;
      sum_n  = sum_q + (smp_en ? SUM_W'(s_avg) : '0);
      spread = (hi_n > lo_n) ? (hi_n - lo_n) : '0;
      res_metric = (spread >= target) ? (spread - target) : (target - spread);
      res_avg    = SMP_W'(sum_n >> dwell_log2);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         hi_q  <= '0;
         lo_q  <= '1;
         sum_q <= '0;
      end else if (smp_en) begin
         hi_q  <= hi_n;
         lo_q  <= lo_n;
         sum_q <= sum_n;
      end
   end
endmodule

// File: rtl/lcal_res_buf.sv
module lcal_res_buf #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4,
   parameter int DW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [DW-1:0]    wmetric,
   input  logic [DW-1:0]    wavg,
   input  logic [IDX_W-1:0] ridx_a,
   output logic [DW-1:0]    rmetric_a,
   input  logic [IDX_W-1:0] ridx_b,
   output logic [DW-1:0]    rmetric_b,
   output logic [DW-1:0]    ravg_b
);
   logic [DW-1:0] met_q [DEPTH];
   logic [DW-1:0] avg_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            met_q[g] <= '0;
            avg_q[g] <= '0;
         end else if (we && (widx == IDX_W'(g))) begin
            met_q[g] <= wmetric;
            avg_q[g] <= wavg;
         end
      end
   end

   assign rmetric_a = met_q[ridx_a];
   assign rmetric_b = met_q[ridx_b];
   assign ravg_b    = avg_q[ridx_b];
endmodule

// File: rtl/lcal_best_pick.sv
module lcal_best_pick #(
   parameter int CODE_W  = 8,
   parameter int M_W     = 8,
   parameter bit TIE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              valid,
   input  logic [M_W-1:0]    metric,
   input  logic [CODE_W-1:0] code,
   output logic [CODE_W-1:0] best_code_n
);
   logic              have_q, better;
   logic [M_W-1:0]    bm_q;
   logic [CODE_W-1:0] bc_q;

   if (TIE_LOW) begin : g_keep_first
      assign better = !have_q || (metric < bm_q);
   end else begin : g_keep_last
      assign better = !have_q || (metric <= bm_q);
   end

   assign best_code_n = (valid && better) ? code : bc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         have_q <= 1'b0;
         bm_q   <= '1;
         bc_q   <= '0;
      end else if (valid && better) begin
         have_q <= 1'b1;
         bm_q   <= metric;
         bc_q   <= code;
      end
   end
endmodule

// File: rtl/laser_cal_seq.sv
module laser_cal_seq
   import lcal_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int SMP_W       = 8,
   parameter int STEPS       = 16,
   parameter int DIV_W       = 16,
   parameter int DWELL_LOG_W = 3,
   parameter bit TIE_LOW     = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       abort,
   input  logic [DIV_W-1:0]           div_limit,
   input  logic [DWELL_LOG_W-1:0]     dwell_log2,
   input  logic [SMP_W-1:0]           target_spread,
   input  logic [SMP_W-1:0]           smp_max,
   input  logic [SMP_W-1:0]           smp_min,
   input  logic [SMP_W-1:0]           smp_avg,
   input  logic [$clog2(STEPS)-1:0]   rd_idx,
   output logic [CODE_W-1:0]          power_code,
   output logic                       write_en,
   output logic                       read_en,
   output logic                       busy,
   output logic                       done,
   output logic [CODE_W-1:0]          final_code,
   output logic [SMP_W-1:0]           rd_metric,
   output logic [SMP_W-1:0]           rd_avg
);
   localparam int STEP_W     = $clog2(STEPS);
   localparam int CNT_W      = (1 << DWELL_LOG_W) - 1;
   localparam int CODE_MAX   = (1 << CODE_W) - 1;
   localparam int COARSE_INC = CODE_MAX / (STEPS - 1);
   localparam int HALF       = STEPS / 2;
   localparam int LO_MAX     = CODE_MAX - (STEPS - 1);

   if (STEPS < 2 || (STEPS & (STEPS - 1)) != 0) begin : g_bad_steps
      $error("STEPS must be a power of two of at least 2");
   end
   if (STEPS > CODE_MAX + 1) begin : g_bad_range
      $error("STEPS must not exceed the number of power codes");
   end
   if (DWELL_LOG_W < 1 || DWELL_LOG_W > 4) begin : g_bad_dwell
      $error("DWELL_LOG_W must lie in 1..4");
   end

   lcal_phase_e        phase_q;
   logic               pass_q;
   logic [STEP_W-1:0]  step_q;
   logic [CNT_W-1:0]   dw_q, dw_last;
   logic [CODE_W-1:0]  lo_q, code_q, final_q, eval_code, best_n, next_lo;
   logic               done_q, strobe, start_go, step_end, last_step;
   logic               smp_en, acc_clr, buf_we, best_clr, eval_v;
   logic [SMP_W-1:0]   res_metric, res_avg, eval_metric;

   function automatic logic [CODE_W-1:0] code_at(input logic fine,
                                                 input logic [CODE_W-1:0] lo,
                                                 input logic [STEP_W-1:0] s);
      if (fine) return lo + CODE_W'(s);
      return CODE_W'(int'(s) * COARSE_INC);
   endfunction

   function automatic logic [CODE_W-1:0] window_lo(input logic [CODE_W-1:0] b);
      if (int'(b) < HALF)            return '0;
      if (int'(b) > LO_MAX + HALF)   return CODE_W'(LO_MAX);
      return b - CODE_W'(HALF);
   endfunction

   assign start_go  = (phase_q == PH_IDLE) && start && !abort;
   assign dw_last   = ~({CNT_W{1'b1}} << dwell_log2);
   assign step_end  = strobe && (dw_q == dw_last);
   assign last_step = (step_q == STEP_W'(STEPS - 1));
   assign smp_en    = (phase_q == PH_READ) && strobe;
   assign buf_we    = (phase_q == PH_READ) && step_end;
   assign acc_clr   = buf_we || start_go || abort;
   assign best_clr  = (buf_we && last_step) || start_go;
   assign eval_v    = (phase_q == PH_EVAL);
   assign eval_code = code_at(pass_q, lo_q, step_q);
   assign next_lo   = window_lo(best_n);

   lcal_strobe_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(start_go || abort),
      .limit(div_limit), .strobe(strobe)
   );

   lcal_step_acc #(.SMP_W(SMP_W), .CNT_W(CNT_W), .LOG_W(DWELL_LOG_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(acc_clr), .smp_en(smp_en),
      .dwell_log2(dwell_log2), .target(target_spread),
      .s_max(smp_max), .s_min(smp_min), .s_avg(smp_avg),
      .res_metric(res_metric), .res_avg(res_avg)
   );

   lcal_res_buf #(.DEPTH(STEPS), .IDX_W(STEP_W), .DW(SMP_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .we(buf_we), .widx(step_q),
      .wmetric(res_metric), .wavg(res_avg),
      .ridx_a(step_q), .rmetric_a(eval_metric),
      .ridx_b(rd_idx), .rmetric_b(rd_metric), .ravg_b(rd_avg)
   );

   lcal_best_pick #(.CODE_W(CODE_W), .M_W(SMP_W), .TIE_LOW(TIE_LOW)) u_best (
      .clk(clk), .rst_n(rst_n), .clr(best_clr), .valid(eval_v),
      .metric(eval_metric), .code(eval_code), .best_code_n(best_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         pass_q  <= 1'b0;
         step_q  <= '0;
         dw_q    <= '0;
         lo_q    <= '0;
         code_q  <= '0;
         final_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort) begin
            phase_q <= PH_IDLE;
            code_q  <= '0;
            step_q  <= '0;
            dw_q    <= '0;
         end else begin
            unique case (phase_q)
               PH_IDLE: begin
                  if (start) begin
                     phase_q <= PH_WRITE;
                     pass_q  <= 1'b0;
                     step_q  <= '0;
                     dw_q    <= '0;
                     lo_q    <= '0;
                     code_q  <= code_at(1'b0, '0, '0);
                  end
               end
               PH_WRITE, PH_READ: begin
                  if (strobe) begin
                     if (step_end) begin
                        dw_q <= '0;
                        if (last_step) begin
                           step_q  <= '0;
                           if (phase_q == PH_WRITE) begin
                              phase_q <= PH_READ;
                              code_q  <= code_at(pass_q, lo_q, '0);
                           end else begin
                              phase_q <= PH_EVAL;
                              code_q  <= '0;
                           end
                        end else begin
                           step_q <= step_q + 1'b1;
                           code_q <= code_at(pass_q, lo_q, step_q + 1'b1);
                        end
                     end else begin
                        dw_q <= dw_q + 1'b1;
                     end
                  end
               end
               PH_EVAL: begin
                  step_q <= step_q + 1'b1;
                  if (last_step) begin
                     step_q <= '0;
                     if (!pass_q) begin
                        pass_q  <= 1'b1;
                        lo_q    <= next_lo;
                        phase_q <= PH_WRITE;
                        dw_q    <= '0;
                        code_q  <= next_lo;
                     end else begin
                        phase_q <= PH_IDLE;
                        final_q <= best_n;
                        done_q  <= 1'b1;
                     end
                  end
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign power_code = code_q;
   assign write_en   = (phase_q == PH_WRITE);
   assign read_en    = (phase_q == PH_READ);
   assign busy       = (phase_q != PH_IDLE);
   assign done       = done_q;
   assign final_code = final_q;
endmodule

// File: rtl/lcal_checks.sv
module lcal_checks #(
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              abort,
   input logic [CODE_W-1:0] power_code,
   input logic              write_en,
   input logic              read_en,
   input logic              busy,
   input logic              done
);
   assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (power_code == '0 && !write_en && !busy && !done));

   assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ends_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(write_en && read_en));

   assert_enables_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (write_en || read_en) |-> busy);

   assert_read_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(read_en) |-> $past(write_en));

   assert_busy_opens_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> write_en);

   assert_code_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (write_en && $past(write_en)) |-> (power_code >= $past(power_code)));
endmodule

bind laser_cal_seq lcal_checks #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .abort(abort), .power_code(power_code),
   .write_en(write_en), .read_en(read_en), .busy(busy), .done(done)
);

// File: tb/sim_laser_cal_seq.sv
module sim_laser_cal_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       abort = 1'b0;
   logic [15:0] div_limit = '0;
   logic [2:0] dwell_log2 = '0;
   logic [7:0] target_spread = '0;
   logic [7:0] smp_max, smp_min, smp_avg;
   logic [3:0] rd_idx = '0;
   logic [7:0] power_code, final_code, rd_metric, rd_avg;
   logic       write_en, read_en, busy, done;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int peak_q  = 0;

   always #5 clk = ~clk;

   // Readback model: spread = target + metric(code), trough fixed, mean = code/2
   function automatic int metric_of(input int code, input int p);
      int d;
      d = (code > p) ? (code - p) : (p - code);
      d = d >> 1;
      return (d > 100) ? 100 : d;
   endfunction

   assign smp_min = 8'd40;
   assign smp_max = 8'(40 + int'(target_spread) + metric_of(int'(power_code), peak_q));
   assign smp_avg = power_code >> 1;

   laser_cal_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .div_limit(div_limit), .dwell_log2(dwell_log2), .target_spread(target_spread),
      .smp_max(smp_max), .smp_min(smp_min), .smp_avg(smp_avg), .rd_idx(rd_idx),
      .power_code(power_code), .write_en(write_en), .read_en(read_en),
      .busy(busy), .done(done), .final_code(final_code),
      .rd_metric(rd_metric), .rd_avg(rd_avg)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   function automatic int coarse_best(input int p);
      int b, bm;
      b = 0; bm = 1000;
      for (int k = 0; k < 16; k++)
         if (metric_of(17 * k, p) < bm) begin bm = metric_of(17 * k, p); b = 17 * k; end
      return b;
   endfunction

   function automatic int fine_lo(input int b);
      if (b < 8) return 0;
      if (b > 248) return 240;
      return b - 8;
   endfunction

   function automatic int fine_best(input int lo, input int p);
      int b, bm;
      b = lo; bm = 1000;
      for (int i = 0; i < 16; i++)
         if (metric_of(lo + i, p) < bm) begin bm = metric_of(lo + i, p); b = lo + i; end
      return b;
   endfunction

   // fields: peak position, target spread, dwell log2, divider limit
   localparam logic [31:0] VEC [8] = '{
      {8'd5,   8'd20, 8'd0, 8'd0},
      {8'd100, 8'd50, 8'd2, 8'd3},
      {8'd255, 8'd30, 8'd1, 8'd1},
      {8'd0,   8'd10, 8'd3, 8'd0},
      {8'd128, 8'd64, 8'd2, 8'd2},
      {8'd250, 8'd90, 8'd0, 8'd2},
      {8'd17,  8'd40, 8'd1, 8'd0},
      {8'd200, 8'd5,  8'd2, 8'd1}
   };

   task automatic run_cal(input int p, input int tgt, input int dl, input int dv);
      int lo, exp_final, ovl, seen_w, read_before_write;
      peak_q = p; target_spread = 8'(tgt); dwell_log2 = 3'(dl); div_limit = 16'(dv);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 busy after start", int'(busy), 1);
      chk("R2 write first", int'(write_en), 1);
      ovl = 0; seen_w = 0; read_before_write = 0;
      while (!done) begin
         if (write_en && read_en) ovl++;
         if (write_en) seen_w = 1;
         if (read_en && !seen_w) read_before_write = 1;
         @(negedge clk);
      end
      chk("R2 enables overlap", ovl, 0);
      chk("R2 read before write", read_before_write, 0);
      chk("R1 busy low at done", int'(busy), 0);
      lo = fine_lo(coarse_best(p));
      exp_final = fine_best(lo, p);
      chk("R6 R7 final code", int'(final_code), exp_final);
      @(negedge clk);
      chk("R1 done single cycle", int'(done), 0);
      for (int i = 0; i < 16; i += 5) begin
         rd_idx = 4'(i);
         #1;
         chk("R8 R5 metric readback", int'(rd_metric), metric_of(lo + i, p));
         chk("R8 R5 mean readback", int'(rd_avg), (lo + i) >> 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 busy reset", int'(busy), 0);
      chk("R10 done reset", int'(done), 0);
      chk("R10 write_en reset", int'(write_en), 0);
      chk("R10 read_en reset", int'(read_en), 0);
      chk("R10 code reset", int'(power_code), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < 8; v++)
         run_cal(int'(VEC[v][31:24]), int'(VEC[v][23:16]),
                 int'(VEC[v][15:8]), int'(VEC[v][7:0]));

      // R3 R4: step timing with divider 1 and two strobes per step
      peak_q = 60; target_spread = 8'd20; dwell_log2 = 3'd1; div_limit = 16'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R4 code held for dwell", int'(power_code), 0);
      @(negedge clk);
      chk("R3 second coarse code", int'(power_code), 17);
      chk("R3 write enable in step", int'(write_en), 1);

      // R9: abort mid-write
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk("R9 code cleared", int'(power_code), 0);
      chk("R9 write_en cleared", int'(write_en), 0);
      chk("R9 busy cleared", int'(busy), 0);
      repeat (20) @(negedge clk);
      chk("R9 no done after abort", int'(done), 0);

      // recovery after abort, ties resolved low
      run_cal(60, 20, 0, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule